// File: doc/BRIEF.md
# Timer Compare Match Unit

This block watches a free-running timer value and compares it on every clock with a compare register that software writes. When the timer first becomes equal to the compare value, a 4-bit mode field decides the response. The compare output latch can be driven high or low. A flag-only mode raises the interrupt flag and leaves the latch alone. A trigger mode sends a one-cycle request that clears the timer and a one-cycle pulse that starts an analog-to-digital conversion. In trigger mode the compare register sets the timer period.

Every active mode sets a sticky match interrupt flag, and software clears it with a pulse. The latch reaches the pin only while the output-enable input is high. Otherwise the pin is released. Writing zero to the mode field turns compare off and also forces the latch low.

Top module: `tcmp_unit`

## Requirements
- R1: After synchronous reset the latch, the interrupt flag, `tmr_clr_req` and `adc_go` are all 0, and the mode is off (0000).
- R2: A match event happens only in the cycle where `tmr_val` equals the compare value and did not equal it in the previous cycle. A timer that stays at the compare value gives one event.
- R3: In mode 1000, the latch is 1 after the clock edge that closes the match cycle.
- R4: In mode 1001, the latch is 0 after the clock edge that closes the match cycle.
- R5: In mode 1010, a match sets only the flag. The latch keeps its value and no trigger pulse appears.
- R6: In mode 1011, a match makes `tmr_clr_req` and `adc_go` high for exactly one cycle, after the same edge that updates the flag. The latch keeps its value.
- R7: In each of modes 1000 to 1011, a match sets `irq_flag` at the same clock edge as the latch action.
- R8: `irq_flag` stays set until an `irq_clr` pulse clears it. If `irq_clr` and a new match fall in the same cycle, the flag ends up set.
- R9: Any mode value outside 1000 to 1011 disables compare. A match then changes neither the flag, the latch nor the trigger outputs.
- R10: A write of 0000 through `mode_we` forces the latch to 0 at that edge.
- R11: `pin_drv` equals `pin_oe`. `pin_out` equals the latch while `pin_oe` is 1 and is 0 otherwise.
- R12: All 16 bits of the compare register, written through `cmp_we`/`cmp_wdata`, take part in the equality test.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mode_we | input | 1 | Mode register write strobe |
| mode_wdata | input | 4 | New mode value |
| cmp_we | input | 1 | Compare register write strobe |
| cmp_wdata | input | 16 | New compare value |
| tmr_val | input | 16 | Current timer count |
| irq_clr | input | 1 | Pulse that clears the interrupt flag |
| pin_oe | input | 1 | Pin output enable |
| tmr_clr_req | output | 1 | One-cycle timer clear request |
| adc_go | output | 1 | One-cycle conversion start |
| irq_flag | output | 1 | Sticky match interrupt flag |
| pin_out | output | 1 | Pin data |
| pin_drv | output | 1 | Pin drive enable |

## Verification
The assertions assume the timer input is synchronous to `clk`. They also assume that once the timer equals the compare value, it must leave that value for at least one cycle before it can match again. This is why two trigger pulses can never be adjacent. The stimulus changes `tmr_val`, `mode_wdata` and `cmp_wdata` only on the falling clock edge. Before each deliberate match it moves the timer off the compare value, so every match starts from a clean not-equal cycle.

// File: rtl/tcmp_pkg.sv
package tcmp_pkg;
    localparam int TMR_W  = 16;
    localparam int MODE_W = 4;

    localparam logic [MODE_W-1:0] MODE_OFF  = 4'b0000;
    localparam logic [MODE_W-1:0] MODE_SET  = 4'b1000;
    localparam logic [MODE_W-1:0] MODE_CLR  = 4'b1001;
    localparam logic [MODE_W-1:0] MODE_SOFT = 4'b1010;
    localparam logic [MODE_W-1:0] MODE_TRIG = 4'b1011;

    // Decoded response to one match event
    typedef struct packed {
        logic drive_hi;
        logic drive_lo;
        logic raise_flag;
        logic fire_trig;
    } act_t;

    function automatic act_t decode_mode(input logic [MODE_W-1:0] m);
        act_t a;
        a = '0;
        case (m)
            MODE_SET:  begin a.drive_hi = 1'b1; a.raise_flag = 1'b1; end
            MODE_CLR:  begin a.drive_lo = 1'b1; a.raise_flag = 1'b1; end
            MODE_SOFT: a.raise_flag = 1'b1;
            MODE_TRIG: begin a.fire_trig = 1'b1; a.raise_flag = 1'b1; end
            default:   a = '0;
        endcase
        return a;
    endfunction
endpackage

// File: rtl/tcmp_match.sv
module tcmp_match
    import tcmp_pkg::*;
#(
    parameter int W = TMR_W
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         cmp_we,
    input  logic [W-1:0] cmp_wdata,
    input  logic [W-1:0] tmr_val,
    output logic         evt
);
    logic [W-1:0] cmp_q;
    logic         eq_now;
    logic         eq_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cmp_q <= '0;
            eq_q  <= 1'b0;
        end else begin
            if (cmp_we) cmp_q <= cmp_wdata;
            eq_q <= eq_now;
        end
    end

    assign eq_now = (tmr_val == cmp_q);
    assign evt    = eq_now && !eq_q;

    // Two events in a row would need the timer to leave the compare value in between
    assert_one_event_R2: assert property (@(posedge clk) disable iff (rst)
        evt |=> !evt);
endmodule

// File: rtl/tcmp_action.sv
module tcmp_action
    import tcmp_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              mode_we,
    input  logic [MODE_W-1:0] mode_wdata,
    input  logic              evt,
    input  logic              irq_clr,
    output logic              latch,
    output logic              flag,
    output logic              trig
);
    logic [MODE_W-1:0] mode_q;
    act_t              act;
    logic              zero_wr;

    assign act     = decode_mode(mode_q);
    assign zero_wr = mode_we && (mode_wdata == MODE_OFF);

    always_ff @(posedge clk) begin
        if (rst) begin
            mode_q <= MODE_OFF;
            latch  <= 1'b0;
            flag   <= 1'b0;
            trig   <= 1'b0;
        end else begin
            if (mode_we) mode_q <= mode_wdata;

            if (zero_wr)                     latch <= 1'b0;
            else if (evt && act.drive_hi)    latch <= 1'b1;
            else if (evt && act.drive_lo)    latch <= 1'b0;

            if (evt && act.raise_flag)       flag <= 1'b1;
            else if (irq_clr)                flag <= 1'b0;

            trig <= evt && act.fire_trig;
        end
    end

    assert_zero_write_R10: assert property (@(posedge clk) disable iff (rst)
        zero_wr |=> !latch);

    assert_latch_hold_R5: assert property (@(posedge clk) disable iff (rst)
        (!mode_we && !act.drive_hi && !act.drive_lo) |=> $stable(latch));

    assert_flag_sticky_R8: assert property (@(posedge clk) disable iff (rst)
        (flag && !irq_clr) |=> flag);

    assert_idle_mode_R9: assert property (@(posedge clk) disable iff (rst)
        (!act.raise_flag && !flag) |=> !flag);

    assert_trig_single_R6: assert property (@(posedge clk) disable iff (rst)
        trig |=> !trig);
endmodule

// File: rtl/tcmp_unit.sv
module tcmp_unit
    import tcmp_pkg::*;
#(
    parameter int W = TMR_W
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         mode_we,
    input  logic [3:0]   mode_wdata,
    input  logic         cmp_we,
    input  logic [W-1:0] cmp_wdata,
    input  logic [W-1:0] tmr_val,
    input  logic         irq_clr,
    input  logic         pin_oe,
    output logic         tmr_clr_req,
    output logic         adc_go,
    output logic         irq_flag,
    output logic         pin_out,
    output logic         pin_drv
);
    logic evt;
    logic latch;
    logic trig;

    tcmp_match #(.W(W)) u_match (
        .clk       (clk),
        .rst       (rst),
        .cmp_we    (cmp_we),
        .cmp_wdata (cmp_wdata),
        .tmr_val   (tmr_val),
        .evt       (evt)
    );

    tcmp_action u_action (
        .clk        (clk),
        .rst        (rst),
        .mode_we    (mode_we),
        .mode_wdata (mode_wdata),
        .evt        (evt),
        .irq_clr    (irq_clr),
        .latch      (latch),
        .flag       (irq_flag),
        .trig       (trig)
    );

    assign tmr_clr_req = trig;
    assign adc_go      = trig;
    assign pin_drv     = pin_oe;
    assign pin_out     = pin_oe & latch;

    // A trigger pulse always comes with the flag set at the same edge
    assert_trig_flag_R7: assert property (@(posedge clk) disable iff (rst)
        tmr_clr_req |-> irq_flag);
endmodule

// File: tb/tcmp_unit_test.sv
module tcmp_unit_test;
    localparam int CLK_PERIOD = 10;
    localparam int W = 16;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         mode_we = 1'b0;
    logic [3:0]   mode_wdata = '0;
    logic         cmp_we = 1'b0;
    logic [W-1:0] cmp_wdata = '0;
    logic [W-1:0] tmr_val = 16'h1234;
    logic         irq_clr = 1'b0;
    logic         pin_oe = 1'b1;
    logic         tmr_clr_req, adc_go, irq_flag, pin_out, pin_drv;

    int n_chk = 0;
    int n_fail = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    tcmp_unit uut (
        .clk(clk), .rst(rst), .mode_we(mode_we), .mode_wdata(mode_wdata),
        .cmp_we(cmp_we), .cmp_wdata(cmp_wdata), .tmr_val(tmr_val),
        .irq_clr(irq_clr), .pin_oe(pin_oe), .tmr_clr_req(tmr_clr_req),
        .adc_go(adc_go), .irq_flag(irq_flag), .pin_out(pin_out), .pin_drv(pin_drv)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic step();
        @(negedge clk);
    endtask

    task automatic write_mode(input logic [3:0] m);
        mode_we = 1'b1; mode_wdata = m; step(); mode_we = 1'b0;
    endtask

    task automatic write_cmp(input logic [W-1:0] c);
        cmp_we = 1'b1; cmp_wdata = c; step(); cmp_we = 1'b0;
    endtask

    task automatic clear_flag();
        irq_clr = 1'b1; step(); irq_clr = 1'b0;
    endtask

    // Drive latch to a known value: 1 via a mode 1000 match, 0 via a zero write
    task automatic preset_latch(input logic v, input logic [W-1:0] c);
        if (v) begin
            write_mode(4'b1000);
            tmr_val = c + 1; step();
            tmr_val = c; step();
        end else begin
            write_mode(4'b0000);
        end
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        logic [W-1:0] c;
        logic exp_latch, active;
        step(); step();
        rst = 1'b0;
        step();
        // R1 reset state
        check("R1 latch", pin_out, 0);
        check("R1 flag", irq_flag, 0);
        check("R1 clr", tmr_clr_req, 0);
        check("R1 adc", adc_go, 0);
        // R1 mode off: a match does nothing
        tmr_val = 16'h0000; step(); step();
        check("R1 mode off flag", irq_flag, 0);

        c = 16'h5A3C;
        write_cmp(c);
        // Sweep all 16 mode values with both latch presets
        for (int m = 0; m < 16; m++) begin
            for (int p = 0; p < 2; p++) begin
                preset_latch(p[0], c);
                write_mode(m[3:0]);
                tmr_val = c + 1;
                clear_flag();
                check("R9 flag cleared before match", irq_flag, 0);
                active = (m >= 8 && m <= 11);
                if (m == 8) exp_latch = 1'b1;
                else if (m == 9 || m == 0) exp_latch = 1'b0;
                else exp_latch = p[0];
                tmr_val = c; step();
                check(m == 8 ? "R3 latch" : m == 9 ? "R4 latch" : m == 0 ? "R10 latch" :
                      (m == 10 ? "R5 latch" : m == 11 ? "R6 latch" : "R9 latch"),
                      pin_out, exp_latch);
                check(active ? "R7 flag" : "R9 flag", irq_flag, active);
                check(m == 11 ? "R6 clr pulse" : "R5 R9 no clr", tmr_clr_req, m == 11);
                check(m == 11 ? "R6 adc pulse" : "R5 R9 no adc", adc_go, m == 11);
                step();
                check("R6 clr one cycle", tmr_clr_req, 0);
                check("R6 adc one cycle", adc_go, 0);
                check("R8 flag sticky", irq_flag, active);
                clear_flag();
                step();
                check("R2 stalled timer no repeat", irq_flag, 0);
                check("R2 latch steady", pin_out, exp_latch);
            end
        end

        // R8 match wins over simultaneous clear
        write_mode(4'b1010);
        tmr_val = c + 1; step();
        irq_clr = 1'b1; tmr_val = c; step(); irq_clr = 1'b0;
        check("R8 match beats clear", irq_flag, 1);
        clear_flag();
        check("R8 clear pulse", irq_flag, 0);

        // R11 pin release
        preset_latch(1'b1, c);
        pin_oe = 1'b0; #1;
        check("R11 released drv", pin_drv, 0);
        check("R11 released out", pin_out, 0);
        pin_oe = 1'b1; #1;
        check("R11 driven drv", pin_drv, 1);
        check("R11 driven out", pin_out, 1);
        step();

        // R12 every compare bit matters
        write_mode(4'b1010);
        for (int b = 0; b < W; b++) begin
            logic [W-1:0] cv;
            cv = W'(1) << b;
            cv = cv | 16'h0001;
            write_cmp(cv);
            tmr_val = cv ^ (W'(1) << b);
            if (b == 0) tmr_val = 16'h0000;
            clear_flag();
            step();
            check("R12 mismatch bit", irq_flag, 0);
            tmr_val = cv; step();
            check("R12 match bit", irq_flag, 1);
        end

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule